// File: doc/BRIEF.md
# Strap-Selected Boot Address Remapper

This block sits between a 16-bit processor address bus and an on-chip flash array. When reset is released, it captures the level of a boot-select strap pin, and that level chooses one of two address views. In the normal view every address reaches the flash unchanged, and execution starts from the program area at address zero. In the in-system-programming view the lowest 4 KB of the processor's address space is redirected near the top of the array. It becomes a 1 KB window repeated four times. Each copy holds a 512-byte recovery boot region at physical 0xFC00–0xFDFF, followed by a 512-byte test region at physical 0xFE00–0xFFFF.

The test region is read-only in both views. A write strobe aimed at it, whether through the mirrored window or at its physical address, never reaches the flash. Instead, the block raises a one-cycle violation pulse. Address translation is combinational and adds no latency. Only the captured mode and the violation pulse are registered. The strap passes through a two-flop synchronizer. The mode follows the synchronized strap while reset is held and freezes on release.

Top module: `boot_remap`

## Requirements
- R1: The mode is the synchronized strap level present when reset is released: 1 selects the remapped view and 0 the normal view. A later reset with a different strap level changes the view.
- R2: In the remapped view, a processor address below 0x0400 maps to 0xFC00 | addr[9:0]. Addresses 0x0000–0x01FF therefore land in the boot region at 0xFC00–0xFDFF, and 0x0200–0x03FF land in the test region at 0xFE00–0xFFFF.
- R3: In the remapped view, addresses 0x0400–0x0FFF repeat the same 1 KB mapping. For example, 0x0400 maps to 0xFC00 and 0x0FFF maps to 0xFFFF.
- R4: Addresses at or above 0x1000 reach the flash unchanged in both views.
- R5: In the normal view, every address reaches the flash unchanged, including 0x0000–0x0FFF.
- R6: Once reset is released, changes on the strap have no effect on the view until the next reset.
- R7: A write whose physical address falls in 0xFE00–0xFFFF gives flash_we = 0. On the next clock, acc_viol is 1 for exactly one cycle per violating write. acc_viol is 0 during reset.
- R8: A write to any other physical address gives flash_we = 1 in the same cycle. Reads are never blocked, so flash_re follows rd_en in the same cycle in both views.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release freezes the mode |
| boot_strap | input | 1 | Boot-select strap pin, asynchronous |
| cpu_addr | input | 16 | Processor byte address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| flash_addr | output | 16 | Physical flash address |
| flash_re | output | 1 | Read strobe to flash |
| flash_we | output | 1 | Write strobe to flash, blocked for the test region |
| acc_viol | output | 1 | One-cycle pulse after a blocked write |

## Verification
Some properties are checked on every cycle. These are: the pass-through of high addresses, the unchanged path in the normal view, the low ten bits and boot-base placement in the remapped view, the absence of a write strobe into the test region, the pulse that follows a blocked write, and the stability of the captured mode after release. Other behaviour needs the bench's scenarios. This covers the exact edge addresses of the mirror (0x01FF/0x0200, 0x03FF/0x0400, 0x0FFF/0x1000), the capture of the strap at reset release, and the return to the remapped view after a normal-view reset. It also covers the proof that toggling the strap later leaves the view alone.

// File: rtl/boot_remap.sv
module boot_remap #(
  parameter int unsigned AW        = 16,
  parameter int unsigned BOOT_BASE = 16'hFC00,
  parameter int unsigned WIN_W     = 10,
  parameter int unsigned REGION_W  = 9,
  parameter int unsigned LIMIT     = 16'h1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_strap,
  input  logic [AW-1:0] cpu_addr,
  input  logic          rd_en,
  input  logic          wr_en,
  output logic [AW-1:0] flash_addr,
  output logic          flash_re,
  output logic          flash_we,
  output logic          acc_viol
);
  localparam logic [AW-1:0] BASE_V  = AW'(BOOT_BASE);
  localparam logic [AW-1:0] TEST_V  = AW'(BOOT_BASE + (1 << REGION_W));
  localparam logic [AW-1:0] LIMIT_V = AW'(LIMIT);

  logic strap_s1, strap_s2, isp_mode, viol_q;
  logic remap, test_hit;

  always_ff @(posedge clk) begin
    strap_s1 <= boot_strap;
    strap_s2 <= strap_s1;
  end

  always_ff @(posedge clk)
    if (!rst_n) isp_mode <= strap_s2;

  assign remap      = isp_mode && (cpu_addr < LIMIT_V);
  assign flash_addr = remap ? {BASE_V[AW-1:WIN_W], cpu_addr[WIN_W-1:0]} : cpu_addr;
  assign test_hit   = flash_addr[AW-1:REGION_W] == TEST_V[AW-1:REGION_W];
  assign flash_we   = wr_en && !test_hit;
  assign flash_re   = rd_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= wr_en && test_hit;

  assign acc_viol = viol_q;
endmodule

// File: rtl/boot_remap_chk.sv
module boot_remap_chk #(
  parameter int unsigned AW        = 16,
  parameter int unsigned BOOT_BASE = 16'hFC00,
  parameter int unsigned WIN_W     = 10,
  parameter int unsigned REGION_W  = 9,
  parameter int unsigned LIMIT     = 16'h1000
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cpu_addr,
  input logic          wr_en,
  input logic          isp_mode,
  input logic [AW-1:0] flash_addr,
  input logic          flash_we,
  input logic          acc_viol
);
  localparam logic [AW-1:0] BASE_V  = AW'(BOOT_BASE);
  localparam logic [AW-1:0] TEST_V  = AW'(BOOT_BASE + (1 << REGION_W));
  localparam logic [AW-1:0] LIMIT_V = AW'(LIMIT);

  AST_HIGH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr >= LIMIT_V |-> flash_addr == cpu_addr); // R4

  AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !isp_mode |-> flash_addr == cpu_addr); // R5

  AST_LOW_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (isp_mode && cpu_addr < LIMIT_V) |->
      (flash_addr[WIN_W-1:0] == cpu_addr[WIN_W-1:0] && flash_addr >= BASE_V)); // R2

  AST_TEST_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    flash_addr >= TEST_V |-> !flash_we); // R7

  AST_VIOL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && flash_addr >= TEST_V) |=> acc_viol); // R7

  AST_WE_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && flash_addr < TEST_V) |-> flash_we); // R8

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(isp_mode)); // R6
endmodule

bind boot_remap boot_remap_chk #(
  .AW(AW), .BOOT_BASE(BOOT_BASE), .WIN_W(WIN_W), .REGION_W(REGION_W), .LIMIT(LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .wr_en(wr_en),
  .isp_mode(isp_mode), .flash_addr(flash_addr), .flash_we(flash_we),
  .acc_viol(acc_viol)
);

// File: tb/sim_boot_remap.sv
`timescale 1ns/1ps
module sim_boot_remap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_strap = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] flash_addr;
  logic        flash_re, flash_we, acc_viol;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit isp_ref = 0;

  typedef struct {
    logic [15:0] addr;
    logic        re;
    logic        we;
    logic        viol;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  boot_remap u0 (
    .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap), .cpu_addr(cpu_addr),
    .rd_en(rd_en), .wr_en(wr_en), .flash_addr(flash_addr), .flash_re(flash_re),
    .flash_we(flash_we), .acc_viol(acc_viol)
  );

  function automatic logic [15:0] ref_map(bit isp, logic [15:0] a);
    if (isp && a < 16'h1000) return 16'hFC00 | {6'd0, a[9:0]};
    return a;
  endfunction

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [15:0] a, logic rd, logic wr, string tag);
    exp_t e;
    logic [15:0] p;
    @(negedge clk);
    cpu_addr = a; rd_en = rd; wr_en = wr;
    p = ref_map(isp_ref, a);
    e.addr = p;
    e.re   = rd;
    e.we   = wr && (p < 16'hFE00);
    e.viol = wr && (p >= 16'hFE00);
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic do_reset(bit strap);
    @(negedge clk);
    rst_n = 1'b0; boot_strap = strap; cpu_addr = '0; rd_en = 0; wr_en = 0;
    repeat (6) @(negedge clk);
    check(acc_viol == 1'b0, "R7 reset viol", {15'd0, acc_viol}, 16'h0);
    rst_n = 1'b1;
    isp_ref = strap;
    @(negedge clk);
    boot_strap = ~strap; // R6: later strap changes must be ignored
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(flash_addr == e.addr, {e.tag, " addr"}, flash_addr, e.addr);
        check(flash_re == e.re, {e.tag, " re"}, {15'd0, flash_re}, {15'd0, e.re});
        check(flash_we == e.we, {e.tag, " we"}, {15'd0, flash_we}, {15'd0, e.we});
        check(acc_viol == e.viol, {e.tag, " viol"}, {15'd0, acc_viol}, {15'd0, e.viol});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin : stim
    do_reset(1'b1);
    drive(16'h0000, 1, 0, "R1 R2 isp 0x0000");
    drive(16'h01FF, 1, 0, "R2 isp 0x01FF");
    drive(16'h0200, 1, 0, "R2 isp 0x0200");
    drive(16'h03FF, 1, 0, "R2 isp 0x03FF");
    drive(16'h0400, 1, 0, "R3 isp 0x0400");
    drive(16'h0A55, 1, 0, "R3 isp 0x0A55");
    drive(16'h0FFF, 1, 0, "R3 isp 0x0FFF");
    drive(16'h1000, 1, 0, "R4 isp 0x1000");
    drive(16'hABCD, 0, 0, "R4 isp 0xABCD");
    drive(16'h0010, 0, 1, "R8 isp write boot");
    drive(16'h0300, 0, 1, "R7 isp write mirrored test");
    drive(16'h0300, 0, 0, "R7 pulse ends");
    drive(16'h0E00, 0, 1, "R7 isp write mirror3 test");
    drive(16'hFE10, 0, 1, "R7 isp write physical test");
    drive(16'h1000, 0, 1, "R8 isp write 0x1000");
    drive(16'h0200, 1, 0, "R8 isp read test");
    drive(16'h0000, 0, 0, "R6 strap toggled isp held");

    do_reset(1'b0);
    drive(16'h0000, 1, 0, "R1 R5 normal 0x0000");
    drive(16'h0200, 1, 0, "R5 normal 0x0200");
    drive(16'h0FFF, 1, 0, "R5 normal 0x0FFF");
    drive(16'h1000, 1, 0, "R4 normal 0x1000");
    drive(16'h0300, 0, 1, "R8 normal write 0x0300");
    drive(16'hFF00, 0, 1, "R7 normal write test");
    drive(16'hFF00, 1, 0, "R8 normal read test");
    drive(16'h0400, 0, 0, "R6 strap toggled normal held");

    do_reset(1'b1);
    drive(16'h0400, 1, 0, "R1 isp again 0x0400");
    drive(16'h0000, 0, 0, "R1 idle");

    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule